// File: doc/BRIEF.md
# Bit-Serial AND-Accumulate Dot-Product Engine

This block forms one signed dot product between a bank of stored lane weights and a vector of input activations. Weights are written once into a small register bank, one lane at a time, and then stay there while many input vectors are streamed against them. Each input vector arrives as a sequence of bit-planes, least significant plane first. A bit-plane is one bit from every lane. For each plane, every lane ANDs its input bit with its stored weight. The lane results are summed. The sum is shifted by the plane's bit position and added into a 40-bit accumulator.

The weight precision is chosen per computation from four settings: 2, 4, 8 or 16 bits. The input width can be any count from 1 to 16 planes. Inputs are unsigned unless signed mode is selected; in signed mode the top plane carries negative weight. A plane with no set bit on any active lane is consumed without touching the accumulator, but it still advances the bit position. A lane whose weight is zero at the selected precision is gated off: its product is forced to zero whatever its input bit.

Handshake rules:
- The plane stream is valid/ready. A plane transfers on a cycle where `in_valid` and `in_ready` are both high.
- The result is valid/ready. `res_valid` rises the cycle after the final plane transfers, and `res_valid` and `res_data` then hold until `res_ready` is seen high.
- `in_ready` drops only while a result is waiting and `res_ready` is low. A producer can therefore stream the next vector straight behind a result that is taken at once.

Top module: `bsmac_engine`

## Requirements
- R1: A cycle with `wt_we` high stores `wt_data` into lane `wt_addr` on the next edge. Stored weights persist unchanged across any number of computations until that lane is written again.
- R2: The weight precision is selected by `cfg_prec`: code 0 selects 2 bits, 1 selects 4, 2 selects 8 and 3 selects 16. The low bits of the stored word are read as two's complement and sign-extended. Stored bits above the selected precision are ignored.
- R3: Plane k (k = 0 for the first plane of a vector) carries bit k of every lane's input, with lane i on `in_plane[i]`. In unsigned mode the result is the sum over lanes of weight times input.
- R4: With `cfg_signed` = 1, the plane at index `cfg_nbits_m1` is the sign bit of a two's-complement input and carries weight -2^k.
- R5: A transferred plane with `in_first` high starts a computation. It clears the accumulator and latches `cfg_prec`, `cfg_signed` and `cfg_nbits_m1`. The computation ends at plane index `cfg_nbits_m1`, or earlier on a plane marked `in_last`. An early end leaves the missing upper planes as zero, so no sign plane is applied.
- R6: `res_valid` is high in the cycle right after the final plane transfers. `res_data` then holds the 40-bit two's-complement dot product.
- R7: A plane with no set bit on any active lane leaves the accumulator unchanged. The bit position still advances, so later planes keep their correct weight.
- R8: A lane whose weight is zero at the selected precision contributes nothing, even when its input bits are set.
- R9: `in_ready` is low exactly while `res_valid` is high and `res_ready` is low. While the result is not taken, `res_valid` and `res_data` hold.
- R10: A plane without `in_first` that transfers while no computation is running is consumed with no effect. A plane with `in_first` during a computation abandons it and starts a new one.
- R11: Changes on `cfg_prec`, `cfg_signed` and `cfg_nbits_m1` after the first plane do not affect the running computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wt_we | input | 1 | Weight write strobe |
| wt_addr | input | 3 | Lane index for a weight write |
| wt_data | input | 16 | Weight word |
| cfg_prec | input | 2 | Weight precision code (0:2, 1:4, 2:8, 3:16 bits) |
| cfg_signed | input | 1 | Treat inputs as two's complement |
| cfg_nbits_m1 | input | 4 | Input plane count minus one |
| in_valid | input | 1 | Plane stream valid |
| in_ready | output | 1 | Plane stream ready |
| in_plane | input | 8 | One input bit per lane |
| in_first | input | 1 | Plane is bit 0 of a new vector |
| in_last | input | 1 | Plane is the final plane of the vector |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| res_data | output | 40 | Signed dot product |

## Verification
Some properties are checked on every cycle by assertions:
- A skipped plane never disturbs the accumulator.
- A gated or idle set of lanes yields a zero tree sum.
- The latched precision and the bit counter only move on a transferred plane.
- A waiting result stays frozen under back-pressure.

Other behaviour only the bench's scenarios can show, because it depends on arithmetic across a whole vector:
- That the shifted plane sums add up to the true dot product at every precision.
- That the sign plane is subtracted only when the full count is reached.
- That a restart or a stray plane leaves no trace in a later result.

// File: rtl/bsmac_pkg.sv
package bsmac_pkg;

  localparam int WMAX = 16;

  typedef enum logic [1:0] {
    WP_2  = 2'd0,
    WP_4  = 2'd1,
    WP_8  = 2'd2,
    WP_16 = 2'd3
  } wprec_e;

  // Read the low bits of a stored word at the chosen precision and sign-extend.
  function automatic logic [WMAX-1:0] wt_extend(input logic [WMAX-1:0] w, input wprec_e p);
    logic [WMAX-1:0] r;
    case (p)
      WP_2:    r = {{(WMAX-2){w[1]}}, w[1:0]};
      WP_4:    r = {{(WMAX-4){w[3]}}, w[3:0]};
      WP_8:    r = {{(WMAX-8){w[7]}}, w[7:0]};
      default: r = w;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bsmac_wt_bank.sv
module bsmac_wt_bank
  import bsmac_pkg::*;
#(
  parameter int N_LANES = 8,
  localparam int AW = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [WMAX-1:0]               data,
  input  wprec_e                        prec,
  output logic [N_LANES-1:0][WMAX-1:0]  wext,
  output logic [N_LANES-1:0]            lane_en
);

  logic [N_LANES-1:0][WMAX-1:0] wreg;

  for (genvar j = 0; j < N_LANES; j++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)                             wreg[j] <= '0;
      else if (we && (addr == AW'(j)))        wreg[j] <= data;
    end
    assign wext[j]    = wt_extend(wreg[j], prec);
    assign lane_en[j] = |wext[j];
  end

  // R1
  weight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(wreg));

endmodule

// File: rtl/bsmac_and_tree.sv
module bsmac_and_tree
  import bsmac_pkg::*;
#(
  parameter int N_LANES = 8,
  localparam int SUM_W = WMAX + $clog2(N_LANES) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_LANES-1:0]            plane,
  input  logic [N_LANES-1:0]            lane_en,
  input  logic [N_LANES-1:0][WMAX-1:0]  wext,
  output logic signed [SUM_W-1:0]       tree_sum,
  output logic                          plane_hit
);

  logic [N_LANES-1:0]            bit_on;
  logic [N_LANES-1:0][SUM_W-1:0] prod;

  for (genvar j = 0; j < N_LANES; j++) begin : g_and
    // Gated lane: a disabled lane presents a constant zero.
    assign bit_on[j] = plane[j] & lane_en[j];
    assign prod[j]   = bit_on[j] ? {{(SUM_W-WMAX){wext[j][WMAX-1]}}, wext[j]} : '0;
  end

  always_comb begin
    tree_sum = '0;
    for (int j = 0; j < N_LANES; j++) tree_sum = tree_sum + $signed(prod[j]);
  end

  assign plane_hit = |bit_on;

  // R8
  gated_sum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((plane & lane_en) == '0) |-> (tree_sum == '0));

endmodule

// File: rtl/bsmac_seq_ctrl.sv
module bsmac_seq_ctrl
  import bsmac_pkg::*;
#(
  parameter int MAX_IN_BITS = 16,
  localparam int PW = $clog2(MAX_IN_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic          in_last,
  input  logic          res_ready,
  input  wprec_e        cfg_prec,
  input  logic          cfg_signed,
  input  logic [PW-1:0] cfg_nbits_m1,
  output logic          in_ready,
  output logic          take,
  output logic          take_first,
  output logic [PW-1:0] pos_eff,
  output logic          neg_plane,
  output wprec_e        prec_eff,
  output logic          res_valid
);

  logic          busy_q;
  logic [PW-1:0] pos_q;
  logic [PW-1:0] nbm1_q;
  logic          sgn_q;
  wprec_e        prec_q;
  logic          hs, at_end, sgn_eff;
  logic [PW-1:0] nbm1_eff;

  assign in_ready   = !(res_valid && !res_ready);
  assign hs         = in_valid && in_ready;
  assign take       = hs && (in_first || busy_q);
  assign take_first = hs && in_first;

  // The start plane already uses the configuration being latched.
  assign prec_eff = take_first ? cfg_prec     : prec_q;
  assign sgn_eff  = take_first ? cfg_signed   : sgn_q;
  assign nbm1_eff = take_first ? cfg_nbits_m1 : nbm1_q;
  assign pos_eff  = take_first ? '0           : pos_q;

  assign at_end    = take && (in_last || (pos_eff == nbm1_eff));
  assign neg_plane = sgn_eff && (pos_eff == nbm1_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      pos_q     <= '0;
      nbm1_q    <= '0;
      sgn_q     <= 1'b0;
      prec_q    <= WP_2;
      res_valid <= 1'b0;
    end else begin
      if (take_first) begin
        prec_q <= cfg_prec;
        sgn_q  <= cfg_signed;
        nbm1_q <= cfg_nbits_m1;
      end
      if (take) begin
        busy_q <= !at_end;
        pos_q  <= pos_eff + 1'b1;
      end
      if (at_end)                     res_valid <= 1'b1;
      else if (res_valid && res_ready) res_valid <= 1'b0;
    end
  end

  // R11
  prec_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_first |=> $stable(prec_q) && $stable(sgn_q) && $stable(nbm1_q));

  // R7
  pos_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(pos_q) && $stable(busy_q));

  // R6
  done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_last) |=> res_valid);

endmodule

// File: rtl/bsmac_accum.sv
module bsmac_accum #(
  parameter int SUM_W = 20,
  parameter int PW    = 4,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    take_first,
  input  logic                    plane_hit,
  input  logic                    neg_plane,
  input  logic [PW-1:0]           pos,
  input  logic signed [SUM_W-1:0] tree_sum,
  output logic [ACC_W-1:0]        acc_q
);

  logic signed [ACC_W-1:0] ext, shifted, contrib;

  assign ext     = {{(ACC_W-SUM_W){tree_sum[SUM_W-1]}}, tree_sum};
  assign shifted = ext <<< pos;
  assign contrib = neg_plane ? -shifted : shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else if (take_first) acc_q <= plane_hit ? contrib : '0;
    else if (take && plane_hit) acc_q <= acc_q + contrib;
  end

  // R7
  skip_plane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_first && !plane_hit) |=> $stable(acc_q));

endmodule

// File: rtl/bsmac_engine.sv
module bsmac_engine
  import bsmac_pkg::*;
#(
  parameter int N_LANES     = 8,
  parameter int MAX_IN_BITS = 16,
  parameter int ACC_W       = 40,
  localparam int AW    = (N_LANES > 1) ? $clog2(N_LANES) : 1,
  localparam int PW    = $clog2(MAX_IN_BITS),
  localparam int SUM_W = WMAX + $clog2(N_LANES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wt_we,
  input  logic [AW-1:0]      wt_addr,
  input  logic [WMAX-1:0]    wt_data,
  input  logic [1:0]         cfg_prec,
  input  logic               cfg_signed,
  input  logic [PW-1:0]      cfg_nbits_m1,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [N_LANES-1:0] in_plane,
  input  logic               in_first,
  input  logic               in_last,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [ACC_W-1:0]   res_data
);

  logic [N_LANES-1:0][WMAX-1:0] wext;
  logic [N_LANES-1:0]           lane_en;
  logic signed [SUM_W-1:0]      tree_sum;
  logic                         plane_hit, take, take_first, neg_plane;
  logic [PW-1:0]                pos_eff;
  wprec_e                       prec_eff;

  bsmac_seq_ctrl #(.MAX_IN_BITS(MAX_IN_BITS)) u_ctrl (
    .clk, .rst_n, .in_valid, .in_first, .in_last, .res_ready,
    .cfg_prec(wprec_e'(cfg_prec)), .cfg_signed, .cfg_nbits_m1,
    .in_ready, .take, .take_first, .pos_eff, .neg_plane, .prec_eff, .res_valid
  );

  bsmac_wt_bank #(.N_LANES(N_LANES)) u_bank (
    .clk, .rst_n, .we(wt_we), .addr(wt_addr), .data(wt_data),
    .prec(prec_eff), .wext, .lane_en
  );

  bsmac_and_tree #(.N_LANES(N_LANES)) u_tree (
    .clk, .rst_n, .plane(in_plane), .lane_en, .wext, .tree_sum, .plane_hit
  );

  bsmac_accum #(.SUM_W(SUM_W), .PW(PW), .ACC_W(ACC_W)) u_acc (
    .clk, .rst_n, .take, .take_first, .plane_hit, .neg_plane,
    .pos(pos_eff), .tree_sum, .acc_q(res_data)
  );

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid && $stable(res_data));

  // R9
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !in_ready);

endmodule

// File: tb/tb_bsmac_engine.sv
module tb_bsmac_engine;
  localparam int N = 8;

  logic clk = 0, rst_n = 0;
  logic wt_we = 0; logic [2:0] wt_addr = 0; logic [15:0] wt_data = 0;
  logic [1:0] cfg_prec = 0; logic cfg_signed = 0; logic [3:0] cfg_nbits_m1 = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, res_ready = 1;
  logic [N-1:0] in_plane = 0;
  logic in_ready, res_valid;
  logic [39:0] res_data;

  int checks = 0, errors = 0;
  logic [15:0] wv [N];
  logic [15:0] xv [N];

  always #2 clk = ~clk;

  bsmac_engine dut (.*);

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint wx(input logic [15:0] w, input int p);
    case (p)
      0: return longint'($signed(w[1:0]));
      1: return longint'($signed(w[3:0]));
      2: return longint'($signed(w[7:0]));
      default: return longint'($signed(w));
    endcase
  endfunction

  // Per-cycle behavioural model.
  logic [15:0] m_w [N];
  bit m_busy, m_valid, m_sgn; int m_pos, m_nb, m_prec; longint m_acc;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_acc = 0; m_pos = 0; m_nb = 1; m_prec = 0; m_sgn = 0;
      for (int i = 0; i < N; i++) m_w[i] = 0;
    end else begin
      bit rdy; longint c;
      rdy = !(m_valid && !res_ready);
      if (m_valid && res_ready) m_valid = 0;
      if (in_valid && rdy && (in_first || m_busy)) begin
        if (in_first) begin
          m_prec = cfg_prec; m_nb = cfg_nbits_m1 + 1; m_sgn = cfg_signed; m_pos = 0; m_acc = 0;
        end
        c = 0;
        for (int i = 0; i < N; i++) if (in_plane[i]) c += wx(m_w[i], m_prec);
        c = c * (longint'(1) << m_pos);
        if (m_sgn && m_pos == m_nb - 1) c = -c;
        m_acc += c;
        if (in_last || m_pos == m_nb - 1) begin m_busy = 0; m_valid = 1; end
        else begin m_busy = 1; m_pos++; end
      end
      if (wt_we) m_w[wt_addr] = wt_data;
    end
  end

  bit run_model = 0;
  always @(negedge clk) if (run_model) begin
    chk("R9 in_ready", in_ready, !(m_valid && !res_ready));
    chk("R6 res_valid", res_valid, m_valid);
    if (m_valid) chk("R3 res_data", longint'($signed(res_data)), m_acc);
  end

  // Independent whole-vector expectation.
  function automatic longint exp_dot(input int p, input int nb, input bit sg, input int stop);
    longint s = 0;
    for (int i = 0; i < N; i++) begin
      longint x = 0;
      for (int k = 0; k <= stop; k++) if (xv[i][k]) x += longint'(1) << k;
      if (sg && stop == nb - 1 && xv[i][nb-1]) x -= longint'(1) << nb;
      s += wx(wv[i], p) * x;
    end
    return s;
  endfunction

  task automatic load_weights();
    for (int i = 0; i < N; i++) begin
      @(posedge clk); #1; wt_we = 1; wt_addr = 3'(i); wt_data = wv[i];
    end
    @(posedge clk); #1; wt_we = 0;
  endtask

  task automatic send_plane(input int k, input bit first, input bit last);
    for (int i = 0; i < N; i++) in_plane[i] = xv[i][k];
    in_first = first; in_last = last; in_valid = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic run_vec(input string tag, input int p, input int nb, input bit sg,
                         input int stop, input bit mess_cfg);
    longint e;
    cfg_prec = 2'(p); cfg_signed = sg; cfg_nbits_m1 = 4'(nb - 1);
    for (int k = 0; k <= stop; k++) begin
      send_plane(k, k == 0, (k == stop) && (stop < nb - 1));
      if (mess_cfg && k == 0) begin
        cfg_prec = ~cfg_prec; cfg_signed = ~cfg_signed; cfg_nbits_m1 = 4'd1;
      end
    end
    e = exp_dot(p, nb, sg, stop);
    chk({tag, " R6 done"}, res_valid, 1);
    chk(tag, longint'($signed(res_data)), e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk("R9 reset in_ready", in_ready, 1);
    chk("R6 reset res_valid", res_valid, 0);
    run_model = 1;

    // R1 R3: 8-bit weights, unsigned 8-bit inputs
    wv = '{16'h0003, 16'h00FE, 16'h007F, 16'h0080, 16'h0011, 16'h0000, 16'h00C5, 16'h0042};
    load_weights();
    xv = '{16'd1, 16'd255, 16'd17, 16'd200, 16'd3, 16'd99, 16'd128, 16'd64};
    run_vec("R3 unsigned p8", 2, 8, 0, 7, 0);
    xv = '{16'd9, 16'd0, 16'd33, 16'd1, 16'd250, 16'd7, 16'd5, 16'd12};
    run_vec("R1 reuse weights", 2, 8, 0, 7, 0);

    // R2 precision modes with upper stored bits set
    wv = '{16'hFFF2, 16'h1235, 16'hABC7, 16'h8001, 16'h7FFF, 16'h0F0E, 16'h8000, 16'h5A5B};
    load_weights();
    xv = '{16'd5, 16'd10, 16'd15, 16'd3, 16'd1, 16'd7, 16'd12, 16'd9};
    run_vec("R2 prec2", 0, 4, 0, 3, 0);
    run_vec("R2 prec4", 1, 4, 0, 3, 0);
    xv = '{16'hFFFF, 16'h8001, 16'h1234, 16'h0F0F, 16'hA5A5, 16'h0001, 16'h7FFF, 16'h8000};
    run_vec("R2 prec16 16 planes", 3, 16, 0, 15, 0);

    // R4 signed inputs
    xv = '{16'h00F0, 16'h0081, 16'h007F, 16'h00FF, 16'h0010, 16'h0080, 16'h0001, 16'h00C3};
    run_vec("R4 signed 8b", 2, 8, 1, 7, 0);
    run_vec("R4 signed 1b", 3, 1, 1, 0, 0);
    // R5 early last: no sign plane applied
    run_vec("R5 early last", 2, 8, 1, 3, 0);
    // R7 zero planes interleaved: planes 0,1,3 all zero
    xv = '{16'h0034, 16'h0004, 16'h0030, 16'h0014, 16'h0000, 16'h00F4, 16'h0024, 16'h0010};
    run_vec("R7 skip planes", 2, 8, 0, 7, 0);

    // R8 zero-weight lane: lane 2 effective zero at 2-bit precision
    wv = '{16'h0001, 16'h0002, 16'h0004, 16'h0003, 16'h0001, 16'h0001, 16'h0001, 16'h0001};
    load_weights();
    xv = '{16'd0, 16'd0, 16'd15, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0};
    run_vec("R8 gated lane only", 0, 4, 0, 3, 0);
    chk("R8 gated lane zero", longint'($signed(res_data)), 0);
    xv = '{16'd3, 16'd1, 16'd15, 16'd2, 16'd0, 16'd4, 16'd0, 16'd9};
    run_vec("R8 gated lane mixed", 0, 4, 0, 3, 0);

    // R11 config changed after first plane
    wv = '{16'h0013, 16'hFF80, 16'h0044, 16'h0001, 16'h00F7, 16'h0020, 16'h00AA, 16'h0005};
    load_weights();
    xv = '{16'd40, 16'd2, 16'd255, 16'd128, 16'd6, 16'd77, 16'd31, 16'd90};
    run_vec("R11 cfg frozen", 2, 8, 0, 7, 1);

    // R10 stray plane while idle, then restart mid-vector
    xv = '{16'hFF, 16'hFF, 16'hFF, 16'hFF, 16'hFF, 16'hFF, 16'hFF, 16'hFF};
    send_plane(0, 0, 0);
    cfg_prec = 2; cfg_signed = 0; cfg_nbits_m1 = 7;
    send_plane(0, 1, 0); send_plane(1, 0, 0);
    xv = '{16'd11, 16'd22, 16'd33, 16'd44, 16'd55, 16'd66, 16'd77, 16'd88};
    run_vec("R10 restart", 2, 8, 0, 7, 0);

    // R9 back-pressure
    cfg_prec = 2; cfg_signed = 0; cfg_nbits_m1 = 3;
    send_plane(0, 1, 0); send_plane(1, 0, 0); send_plane(2, 0, 0);
    res_ready = 0;
    send_plane(3, 0, 0);
    for (int n = 0; n < 4; n++) begin
      @(posedge clk); #1;
      chk("R9 held valid", res_valid, 1);
      chk("R9 ready low", in_ready, 0);
      chk("R9 held data", longint'($signed(res_data)), exp_dot(2, 4, 0, 3));
    end
    res_ready = 1;
    @(posedge clk); #1;
    chk("R9 released", res_valid, 0);

    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule